// File: doc/BRIEF.md
# Load-Use Stall Controller

This block keeps a five-stage in-order pipeline correct when an instruction needs a value that a load immediately ahead of it has not yet brought back from memory. It compares the load sitting in the execute stage with the source registers of the instruction being decoded. When they collide, it freezes the fetch address and the decode register for one cycle and sends an all-zero control word into execute in place of the dependent instruction. The dependent instruction then reaches execute one cycle later, when the loaded value can be forwarded from the memory/write-back boundary.

The top module contains the detector and the minimum of pipeline state needed to watch it work: the program counter, the fetch/decode register, the decode/execute control register and the execute/memory control register. Decode itself is outside the block. The instruction fields presented at the fetch inputs (source and destination indices, per-source read flags and the control word) are taken as already decoded. The control word is four bits wide: bit 0 register write, bit 1 memory read (the instruction is a load), bit 2 memory write (the instruction is a store), bit 3 ALU operation.

Top module: `lu_stall_unit`

## Requirements
- R1: `stall` is asserted only while the execute-stage control word has its memory-read bit (bit 1) set. A register-writing non-load ahead of a dependent instruction never stalls.
- R2: A load in execute stalls when its destination equals the decoding instruction's first source (`id_rs`) or its second source (`id_rt`).
- R3: A load whose destination is register 0 never causes a stall.
- R4: In a cycle with `stall` high, `pc_we` is low and `pc` keeps its value at the next rising edge. Otherwise `pc` advances by `PC_STEP`.
- R5: In a cycle with `stall` high, `ifid_we` is low and the fetch/decode register keeps its contents, so the same instruction is decoded again.
- R6: In a cycle with `stall` high, `idex_clear` is high and the next execute-stage control word and destination are all zero.
- R7: Each load-use hazard costs exactly one bubble. `stall` is never high in two consecutive cycles, and a load followed by a load that depends on it stalls exactly once.
- R8: A source index is compared only when its read flag (`f_uses_rs` or `f_uses_rt`, latched into decode) is set.
- R9: When the decoding instruction is a store (control bit 2 set), its second source is store data and is not compared. A store whose base register is the loaded register still stalls.
- R10: The execute/memory register keeps advancing during a stall: each cycle it takes the previous execute-stage control word and destination.
- R11: Synchronous active-high reset sets `pc` to `RESET_PC` and clears all pipeline registers.
- R12: When the dependent instruction is two or more slots behind the load, no stall occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| f_rs | input | 5 | First source index of the fetched instruction |
| f_rt | input | 5 | Second source index of the fetched instruction |
| f_dst | input | 5 | Destination index of the fetched instruction |
| f_ctrl | input | 4 | Control word of the fetched instruction |
| f_uses_rs | input | 1 | Fetched instruction reads its first source |
| f_uses_rt | input | 1 | Fetched instruction reads its second source |
| pc | output | PC_W | Current fetch address |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| idex_clear | output | 1 | Forces zero controls into decode/execute |
| stall | output | 1 | Load-use hazard detected this cycle |
| id_rs | output | 5 | First source index in decode |
| id_rt | output | 5 | Second source index in decode |
| id_dst | output | 5 | Destination index in decode |
| id_ctrl | output | 4 | Control word in decode |
| ex_dst | output | 5 | Destination index in execute |
| ex_ctrl | output | 4 | Control word in execute |
| mem_dst | output | 5 | Destination index in memory stage |
| mem_ctrl | output | 4 | Control word in memory stage |

## Verification
The hardest cases to reach are a hazard that arrives right behind a bubble and a load that depends on the load ahead of it. In both, the execute stage holds a zeroed word at the moment a naive design might stall a second time. The bench feeds short programs from a small instruction table indexed by the fetch address. Because a held `pc` makes the block re-present the same instruction, stalls replay naturally. Programs that chain two loads, separate a load from its user by one slot, or hide a match behind a cleared read flag or a store's data field steer the decode stage into each of these corners.

// File: rtl/lu_pkg.sv
package lu_pkg;
  localparam int REG_AW = 5;
  localparam int CTRL_W = 4;
  localparam int CB_REGW = 0;
  localparam int CB_MRD  = 1;
  localparam int CB_MWR  = 2;
  localparam int CB_ALU  = 3;

  // A source collides with a destination when it is read and indices agree.
  function automatic logic src_hit(input logic used,
                                   input logic [REG_AW-1:0] src,
                                   input logic [REG_AW-1:0] dst);
    return used && (src == dst);
  endfunction
endpackage

// File: rtl/lu_hazard_detect.sv
module lu_hazard_detect
  import lu_pkg::*;
(
  input  logic [CTRL_W-1:0] ex_ctrl,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic [CTRL_W-1:0] id_ctrl,
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic              id_uses_rs,
  input  logic              id_uses_rt,
  output logic              hazard
);
  logic ex_is_load;
  logic dst_live;
  logic rt_compared;
  logic rs_match;
  logic rt_match;

  always_comb begin
    ex_is_load  = ex_ctrl[CB_MRD];
    dst_live    = (ex_dst != '0);
    // store data is consumed later, in the memory stage
    rt_compared = id_uses_rt && !id_ctrl[CB_MWR];
    rs_match    = src_hit(id_uses_rs, id_rs, ex_dst);
    rt_match    = src_hit(rt_compared, id_rt, ex_dst);
    hazard      = ex_is_load && dst_live && (rs_match || rt_match);
  end
endmodule

// File: rtl/lu_pc_counter.sv
module lu_pc_counter #(
  parameter int PC_W     = 32,
  parameter int RESET_PC = 0,
  parameter int PC_STEP  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  output logic [PC_W-1:0] pc
);
  localparam logic [PC_W-1:0] PC_INIT = PC_W'(RESET_PC);
  localparam logic [PC_W-1:0] PC_INC  = PC_W'(PC_STEP);

  always_ff @(posedge clk) begin
    if (rst)     pc <= PC_INIT;
    else if (we) pc <= pc + PC_INC;
  end
endmodule

// File: rtl/lu_stage_reg.sv
module lu_stage_reg #(
  parameter int W         = 8,
  parameter bit CLEARABLE = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (CLEARABLE) begin : g_clr
      always_ff @(posedge clk) begin
        if (rst || clr) q <= '0;
        else if (en)    q <= d;
      end
    end else begin : g_plain
      logic unused_clr;
      assign unused_clr = clr;
      always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (en) q <= d;
      end
    end
  endgenerate
endmodule

// File: rtl/lu_stall_unit.sv
module lu_stall_unit
  import lu_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int RESET_PC = 0,
  parameter int PC_STEP  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] f_rs,
  input  logic [REG_AW-1:0] f_rt,
  input  logic [REG_AW-1:0] f_dst,
  input  logic [CTRL_W-1:0] f_ctrl,
  input  logic              f_uses_rs,
  input  logic              f_uses_rt,
  output logic [PC_W-1:0]   pc,
  output logic              pc_we,
  output logic              ifid_we,
  output logic              idex_clear,
  output logic              stall,
  output logic [REG_AW-1:0] id_rs,
  output logic [REG_AW-1:0] id_rt,
  output logic [REG_AW-1:0] id_dst,
  output logic [CTRL_W-1:0] id_ctrl,
  output logic [REG_AW-1:0] ex_dst,
  output logic [CTRL_W-1:0] ex_ctrl,
  output logic [REG_AW-1:0] mem_dst,
  output logic [CTRL_W-1:0] mem_ctrl
);
  localparam int IFID_W = 3 * REG_AW + CTRL_W + 2;
  localparam int CW_W   = REG_AW + CTRL_W;

  logic [IFID_W-1:0] ifid_d, ifid_q;
  logic [CW_W-1:0]   idex_d, idex_q, exmem_q;
  logic              id_uses_rs, id_uses_rt;
  logic              hazard;

  assign ifid_d = {f_rs, f_rt, f_dst, f_ctrl, f_uses_rs, f_uses_rt};
  assign {id_rs, id_rt, id_dst, id_ctrl, id_uses_rs, id_uses_rt} = ifid_q;
  assign idex_d = {id_dst, id_ctrl};
  assign {ex_dst, ex_ctrl}   = idex_q;
  assign {mem_dst, mem_ctrl} = exmem_q;

  lu_hazard_detect u_det (
    .ex_ctrl    (ex_ctrl),
    .ex_dst     (ex_dst),
    .id_ctrl    (id_ctrl),
    .id_rs      (id_rs),
    .id_rt      (id_rt),
    .id_uses_rs (id_uses_rs),
    .id_uses_rt (id_uses_rt),
    .hazard     (hazard)
  );

  assign stall      = hazard;
  assign pc_we      = !hazard;
  assign ifid_we    = !hazard;
  assign idex_clear = hazard;

  lu_pc_counter #(.PC_W(PC_W), .RESET_PC(RESET_PC), .PC_STEP(PC_STEP)) u_pc (
    .clk (clk), .rst (rst), .we (pc_we), .pc (pc)
  );

  lu_stage_reg #(.W(IFID_W), .CLEARABLE(1'b0)) u_ifid (
    .clk (clk), .rst (rst), .en (ifid_we), .clr (1'b0), .d (ifid_d), .q (ifid_q)
  );

  lu_stage_reg #(.W(CW_W), .CLEARABLE(1'b1)) u_idex (
    .clk (clk), .rst (rst), .en (1'b1), .clr (idex_clear), .d (idex_d), .q (idex_q)
  );

  lu_stage_reg #(.W(CW_W), .CLEARABLE(1'b0)) u_exmem (
    .clk (clk), .rst (rst), .en (1'b1), .clr (1'b0), .d (idex_q), .q (exmem_q)
  );
endmodule

// File: rtl/lu_stall_checker.sv
module lu_stall_checker
  import lu_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int RESET_PC = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              stall,
  input logic [PC_W-1:0]   pc,
  input logic [REG_AW-1:0] id_rs,
  input logic [REG_AW-1:0] id_rt,
  input logic [CTRL_W-1:0] id_ctrl,
  input logic [REG_AW-1:0] ex_dst,
  input logic [CTRL_W-1:0] ex_ctrl,
  input logic [REG_AW-1:0] mem_dst,
  input logic [CTRL_W-1:0] mem_ctrl
);
  assert_needs_load_R1: assert property (@(posedge clk) disable iff (rst)
    stall |-> ex_ctrl[CB_MRD]);

  assert_zero_dst_R3: assert property (@(posedge clk) disable iff (rst)
    (ex_dst == '0) |-> !stall);

  assert_pc_held_R4: assert property (@(posedge clk) disable iff (rst)
    stall |=> (pc == $past(pc)));

  assert_ifid_held_R5: assert property (@(posedge clk) disable iff (rst)
    stall |=> (id_rs == $past(id_rs) && id_rt == $past(id_rt)
               && id_ctrl == $past(id_ctrl)));

  assert_bubble_R6: assert property (@(posedge clk) disable iff (rst)
    stall |=> (ex_ctrl == '0 && ex_dst == '0));

  assert_single_bubble_R7: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall);

  assert_mem_advances_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (mem_ctrl == $past(ex_ctrl) && mem_dst == $past(ex_dst)));

  assert_reset_state_R11: assert property (@(posedge clk)
    rst |=> (pc == PC_W'(RESET_PC) && id_ctrl == '0 && ex_ctrl == '0
             && mem_ctrl == '0));
endmodule

bind lu_stall_unit lu_stall_checker #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .stall    (stall),
  .pc       (pc),
  .id_rs    (id_rs),
  .id_rt    (id_rt),
  .id_ctrl  (id_ctrl),
  .ex_dst   (ex_dst),
  .ex_ctrl  (ex_ctrl),
  .mem_dst  (mem_dst),
  .mem_ctrl (mem_ctrl)
);

// File: tb/sim_lu_stall_unit.sv
module sim_lu_stall_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NPROG = 16;

  typedef struct packed {
    logic [4:0] rs, rt, dst;
    logic [3:0] ctrl;
    logic       urs, urt;
  } ins_t;

  localparam logic [3:0] C_LW  = 4'b1011;
  localparam logic [3:0] C_ADD = 4'b1001;
  localparam logic [3:0] C_SW  = 4'b1100;

  logic clk = 1'b0, rst = 1'b1;
  logic [4:0] f_rs, f_rt, f_dst, id_rs, id_rt, id_dst, ex_dst, mem_dst;
  logic [3:0] f_ctrl, id_ctrl, ex_ctrl, mem_ctrl;
  logic f_uses_rs, f_uses_rt, pc_we, ifid_we, idex_clear, stall;
  logic [31:0] pc;

  ins_t prog [NPROG];
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lu_stall_unit u0 (
    .clk(clk), .rst(rst), .f_rs(f_rs), .f_rt(f_rt), .f_dst(f_dst), .f_ctrl(f_ctrl),
    .f_uses_rs(f_uses_rs), .f_uses_rt(f_uses_rt), .pc(pc), .pc_we(pc_we),
    .ifid_we(ifid_we), .idex_clear(idex_clear), .stall(stall), .id_rs(id_rs),
    .id_rt(id_rt), .id_dst(id_dst), .id_ctrl(id_ctrl), .ex_dst(ex_dst),
    .ex_ctrl(ex_ctrl), .mem_dst(mem_dst), .mem_ctrl(mem_ctrl)
  );

  function automatic ins_t fetch(input int addr);
    int idx = addr / 4;
    if (idx >= 0 && idx < NPROG) return prog[idx];
    return '0;
  endfunction

  always_comb begin
    ins_t cur;
    cur = fetch(int'(pc));
    {f_rs, f_rt, f_dst, f_ctrl, f_uses_rs, f_uses_rt} = cur;
  end

  function automatic ins_t mk(logic [3:0] c, int d, int s, int t, bit us, bit ut);
    ins_t r;
    r.ctrl = c; r.dst = 5'(d); r.rs = 5'(s); r.rt = 5'(t); r.urs = us; r.urt = ut;
    return r;
  endfunction

  // Requirement view of a hazard: load ahead, live destination, read source.
  function automatic bit want_stall(ins_t id, logic [3:0] exc, logic [4:0] exd);
    if (!exc[1] || exd == 5'd0) return 1'b0;
    if (id.urs && id.rs == exd) return 1'b1;
    if (id.urt && !id.ctrl[2] && id.rt == exd) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < NPROG; i++) prog[i] = '0;
  endtask

  // Reset, then compare against the model every cycle; returns stall count.
  task automatic run(input int ncyc, output int nstall);
    int m_pc;
    ins_t m_id;
    logic [3:0] m_exc, m_memc;
    logic [4:0] m_exd, m_memd;
    bit ms;
    nstall = 0;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_pc = 0; m_id = '0; m_exc = '0; m_exd = '0; m_memc = '0; m_memd = '0;
    for (int c = 0; c < ncyc; c++) begin
      ms = want_stall(m_id, m_exc, m_exd);
      if (c == 0) begin
        chk("R11 pc", int'(pc), 0);
        chk("R11 regs", int'({id_ctrl, ex_ctrl, mem_ctrl}), 0);
      end
      chk("R1/R2 stall", int'(stall), int'(ms));
      chk("R4 pc", int'(pc), m_pc);
      chk("R5 ifid", int'({id_rs, id_rt, id_dst, id_ctrl}),
          int'({m_id.rs, m_id.rt, m_id.dst, m_id.ctrl}));
      chk("R6 ex", int'({ex_dst, ex_ctrl}), int'({m_exd, m_exc}));
      chk("R10 mem", int'({mem_dst, mem_ctrl}), int'({m_memd, m_memc}));
      chk("R4 enables", int'({pc_we, ifid_we, idex_clear}), ms ? 1 : 6);
      if (stall) nstall++;
      m_memc = m_exc; m_memd = m_exd;
      if (ms) begin
        m_exc = '0; m_exd = '0;
      end else begin
        m_exc = m_id.ctrl; m_exd = m_id.dst;
        m_id = fetch(m_pc);
        m_pc += 4;
      end
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    // R2: load then user of first source
    clear_prog(); prog[0] = mk(C_LW, 2, 1, 0, 1, 0); prog[1] = mk(C_ADD, 4, 2, 3, 1, 1);
    run(12, n); chk("R2 rs hazard count", n, 1);
    // R2: user of second source
    clear_prog(); prog[0] = mk(C_LW, 3, 1, 0, 1, 0); prog[1] = mk(C_ADD, 4, 5, 3, 1, 1);
    run(12, n); chk("R2 rt hazard count", n, 1);
    // R3: load into register 0
    clear_prog(); prog[0] = mk(C_LW, 0, 1, 0, 1, 0); prog[1] = mk(C_ADD, 4, 0, 0, 1, 1);
    run(12, n); chk("R3 zero dst count", n, 0);
    // R1: non-load writer ahead
    clear_prog(); prog[0] = mk(C_ADD, 2, 1, 1, 1, 1); prog[1] = mk(C_ADD, 4, 2, 2, 1, 1);
    run(12, n); chk("R1 non-load count", n, 0);
    // R8: matching index but read flags clear
    clear_prog(); prog[0] = mk(C_LW, 4, 1, 0, 1, 0); prog[1] = mk(C_ADD, 6, 4, 4, 0, 0);
    run(12, n); chk("R8 unused source count", n, 0);
    // R9: store of loaded value as data only
    clear_prog(); prog[0] = mk(C_LW, 5, 1, 0, 1, 0); prog[1] = mk(C_SW, 0, 1, 5, 1, 1);
    run(12, n); chk("R9 store data count", n, 0);
    // R9: store whose base is the loaded register
    clear_prog(); prog[0] = mk(C_LW, 5, 1, 0, 1, 0); prog[1] = mk(C_SW, 0, 5, 2, 1, 1);
    run(12, n); chk("R9 store base count", n, 1);
    // R7: dependent back-to-back loads
    clear_prog(); prog[0] = mk(C_LW, 1, 2, 0, 1, 0); prog[1] = mk(C_LW, 2, 1, 0, 1, 0);
    run(14, n); chk("R7 load chain count", n, 1);
    // R7: chain of three, each stalls once
    clear_prog(); prog[0] = mk(C_LW, 1, 2, 0, 1, 0); prog[1] = mk(C_LW, 2, 1, 0, 1, 0);
    prog[2] = mk(C_ADD, 3, 2, 2, 1, 1);
    run(16, n); chk("R7 two hazards count", n, 2);
    // R12: one slot between load and user
    clear_prog(); prog[0] = mk(C_LW, 6, 1, 0, 1, 0); prog[1] = '0;
    prog[2] = mk(C_ADD, 7, 6, 6, 1, 1);
    run(12, n); chk("R12 distance two count", n, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule